// File: doc/BRIEF.md
# SONET BIP Parity Byte Generator

This block forms the three bit-interleaved parity bytes that a SONET/SDH transmitter carries in every frame: the section parity (B1), the per-STS-1 line parity (B2) and the path parity (B3). It watches a byte-wide transmit stream. A set of position strobes comes with the stream and says where each byte sits in the frame. The block keeps running even-parity accumulators and hands over each result at the next boundary. An overhead inserter can then place the values into the following frame.

B1 is taken from a tap of the stream after scrambling. B2 and B3 are taken from the stream before scrambling. B2 is kept as a separate byte for each constituent STS-1, even when the frame is concatenated. That gives three bytes for an STS-3c stream and twelve bytes for an STS-12c stream. The frame size is a static input (`sts12_mode`), and it may only change while the block is held in reset.

Every strobe is qualified by `byte_vld`. Cycles without a valid byte are ignored, so the stream may have gaps of any length.

Top module: `sonet_bip_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `b1_out`, `b2_out` and `b3_out` are all zero, and the slice counter starts at slice 0.
- R2: `b1_out` is the XOR of every `post_byte` accepted with `byte_vld`=1. The window runs from a `frame_start` byte up to, but not including, the next `frame_start` byte. The value appears in the cycle after that next `frame_start` byte.
- R3: Each accepted byte is given to a B2 slice by position. The byte with `row_start`=1 is slice 0, and each following accepted byte takes the next slice, wrapping modulo N. N is 3 when `sts12_mode`=0 and 12 when `sts12_mode`=1.
- R4: B2 slice s is the XOR of the `pre_byte` values given to slice s with `loh_row`=1 over one frame window, as in R2. It is shown on `b2_out[8s+7:8s]` from the cycle after the closing `frame_start` byte.
- R5: With `sts12_mode`=0, `b2_out[95:24]` is always zero.
- R6: `b3_out` is the XOR of every accepted `pre_byte` with `spe_vld`=1 and `toh_col`=0. The window runs from one `spe_start` byte up to, but not including, the next. The value appears in the cycle after that next `spe_start` byte.
- R7: A cycle with `byte_vld`=0 has no effect: its data, its strobes and the slice counter are all disregarded.
- R8: `b1_out` and `b2_out` change only in the cycle after an accepted `frame_start`. `b3_out` changes only in the cycle after an accepted `spe_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sts12_mode | input | 1 | 0: three STS-1 slices, 1: twelve slices (static) |
| byte_vld | input | 1 | A stream byte is present this cycle |
| frame_start | input | 1 | First byte of a frame |
| row_start | input | 1 | First byte of a row |
| spe_start | input | 1 | First byte of a synchronous payload envelope |
| loh_row | input | 1 | Byte lies in a line-overhead row (rows 4 to 9) |
| toh_col | input | 1 | Byte lies in a transport-overhead column |
| spe_vld | input | 1 | Byte belongs to the payload envelope |
| pre_byte | input | 8 | Stream byte before scrambling |
| post_byte | input | 8 | Stream byte after scrambling |
| b1_out | output | 8 | Section parity of the previous frame |
| b2_out | output | 96 | Line parity, one byte per slice, slice 0 in the low byte |
| b3_out | output | 8 | Path parity of the previous envelope |

## Verification
The envelope start is placed in the second row, so every B3 window straddles a frame boundary. A design that latched B3 on the frame strobe would report the wrong bytes. Idle cycles carrying random data and stray strobes are mixed into the stream. A design that did not qualify on `byte_vld` would either latch early or step the slice counter, and every B2 byte after that point would come out shuffled. All-zero, all-one and random frames are run in both modes. These catch a wrong wrap point, a missing section-row mask, or upper slices leaking into the 3-slice output.

// File: rtl/sonet_bip_gen.sv
module sonet_bip_gen #(
  parameter int W          = 8,
  parameter int MAX_SLICES = 12,
  parameter int LOW_SLICES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sts12_mode,
  input  logic                    byte_vld,
  input  logic                    frame_start,
  input  logic                    row_start,
  input  logic                    spe_start,
  input  logic                    loh_row,
  input  logic                    toh_col,
  input  logic                    spe_vld,
  input  logic [W-1:0]            pre_byte,
  input  logic [W-1:0]            post_byte,
  output logic [W-1:0]            b1_out,
  output logic [MAX_SLICES*W-1:0] b2_out,
  output logic [W-1:0]            b3_out
);
  localparam int IW = $clog2(MAX_SLICES);

  logic [IW-1:0] idx_q, idx_cur, idx_last;
  logic [W-1:0]  acc1, acc3;
  logic          take_frame, take_spe, b3_hit;

  assign take_frame = byte_vld & frame_start;
  assign take_spe   = byte_vld & spe_start;
  assign b3_hit     = byte_vld & spe_vld & ~toh_col;
  assign idx_last   = sts12_mode ? IW'(MAX_SLICES - 1) : IW'(LOW_SLICES - 1);
  assign idx_cur    = row_start ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        idx_q <= '0;
    else if (byte_vld) idx_q <= (idx_cur == idx_last) ? '0 : idx_cur + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc1   <= '0;
      b1_out <= '0;
    end else if (take_frame) begin
      b1_out <= acc1;
      acc1   <= post_byte;
    end else if (byte_vld) begin
      acc1   <= acc1 ^ post_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc3   <= '0;
      b3_out <= '0;
    end else if (take_spe) begin
      b3_out <= acc3;
      acc3   <= b3_hit ? pre_byte : '0;
    end else if (b3_hit) begin
      acc3   <= acc3 ^ pre_byte;
    end
  end

  for (genvar s = 0; s < MAX_SLICES; s++) begin : g_slice
    logic [W-1:0] acc2, res2;
    logic         hit;
    assign hit = byte_vld & loh_row & (idx_cur == IW'(s)) &
                 ((s < LOW_SLICES) | sts12_mode);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc2 <= '0;
        res2 <= '0;
      end else if (take_frame) begin
        res2 <= acc2;
        acc2 <= hit ? pre_byte : '0;
      end else if (hit) begin
        acc2 <= acc2 ^ pre_byte;
      end
    end
    assign b2_out[s*W +: W] = res2;
  end

  // R3
  slice_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= idx_last);

  // R5
  low_mode_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sts12_mode |-> b2_out[MAX_SLICES*W-1:LOW_SLICES*W] == '0);

  // R8
  b1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_frame |=> $stable(b1_out));

  // R8
  b2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_frame |=> $stable(b2_out));

  // R8
  b3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_spe |=> $stable(b3_out));

  // R7
  idle_slice_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(idx_q));
endmodule

// File: tb/sonet_bip_gen_tb.sv
module sonet_bip_gen_tb;
  logic        clk = 0, rst_n = 0, sts12_mode = 0;
  logic        byte_vld = 0, frame_start = 0, row_start = 0, spe_start = 0;
  logic        loh_row = 0, toh_col = 0, spe_vld = 0;
  logic [7:0]  pre_byte = 0, post_byte = 0;
  logic [7:0]  b1_out, b3_out;
  logic [95:0] b2_out;

  int checks = 0, fails = 0;
  logic [7:0]  a1, a3, e1, e3;
  logic [7:0]  a2 [12];
  logic [95:0] e2;
  int idx;
  bit done = 0;

  always #2 clk = ~clk;

  sonet_bip_gen u_dut (.*);

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] pack2();
    logic [95:0] v;
    for (int s = 0; s < 12; s++) v[s*8 +: 8] = a2[s];
    return v;
  endfunction

  task automatic model_reset();
    a1 = 0; a3 = 0; e1 = 0; e3 = 0; e2 = 0; idx = 0;
    for (int s = 0; s < 12; s++) a2[s] = 0;
  endtask

  task automatic put(bit v, bit fs, bit rs, bit ss, bit loh, bit toh, bit spv,
                     logic [7:0] pre, logic [7:0] post);
    int n, i;
    @(negedge clk);
    byte_vld = v; frame_start = fs; row_start = rs; spe_start = ss;
    loh_row = loh; toh_col = toh; spe_vld = spv; pre_byte = pre; post_byte = post;
    n = sts12_mode ? 12 : 3;
    if (v) begin
      i = rs ? 0 : idx;
      if (fs) begin
        e1 = a1; a1 = 0; e2 = pack2();
        for (int s = 0; s < 12; s++) a2[s] = 0;
      end
      a1 ^= post;
      if (loh) a2[i] ^= pre;
      if (ss) begin e3 = a3; a3 = 0; end
      if (spv && !toh) a3 ^= pre;
      idx = (i == n - 1) ? 0 : i + 1;
    end
    @(posedge clk); #1;
    if (v && fs) begin
      chk("R2 b1", {88'd0, b1_out}, {88'd0, e1});
      chk("R3/R4 b2", b2_out, e2);
      if (!sts12_mode) chk("R5 b2 upper", {24'd0, b2_out[95:24]}, 96'd0);
    end
    if (v && ss) chk("R6 b3", {88'd0, b3_out}, {88'd0, e3});
    if (!v && (fs || ss)) begin
      chk("R7 idle b1", {88'd0, b1_out}, {88'd0, e1});
      chk("R7 idle b3", {88'd0, b3_out}, {88'd0, e3});
    end
  endtask

  task automatic frame(int pat);
    int n, cols, toh;
    logic [7:0] pr, po;
    n = sts12_mode ? 12 : 3; cols = 12 * n; toh = 3 * n;
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < cols; c++) begin
        if ($urandom_range(7) == 0)
          put(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
        case (pat)
          1: begin pr = 8'h00; po = 8'h00; end
          2: begin pr = 8'hFF; po = 8'hFF; end
          3: begin pr = 8'(1 << ((r + c) % 8)); po = ~pr; end
          default: begin pr = 8'($urandom); po = 8'($urandom); end
        endcase
        put(1, r == 0 && c == 0, c == 0, r == 1 && c == toh, r >= 3, c < toh,
            c >= toh, pr, po);
      end
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst_n = 0; sts12_mode = mode; byte_vld = 0;
    repeat (3) @(negedge clk);
    // R1: outputs zero while in reset
    chk("R1 b1", {88'd0, b1_out}, 96'd0);
    chk("R1 b2", b2_out, 96'd0);
    chk("R1 b3", {88'd0, b3_out}, 96'd0);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset(0);
    frame(1); frame(2); frame(0); frame(3); frame(0); frame(1);
    do_reset(1);
    frame(0); frame(2); frame(3); frame(0); frame(1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule